// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit sits between the pads and a region of programmable logic and freezes that region while a power-down request is present. Two pads, chosen by parameter, act as power-down request pins. The request is the OR of the two. It takes effect only when a configuration bit is set, and that bit is captured during reset. While the request is present, the values that the unit presents to the logic array stay frozen, and so do the output data and output enables driven to the pads. An output that was high-Z when the freeze began therefore stays high-Z. A clock-enable output gates the clocks of the region's internal registers so that their state is held.

When both request pins return low, a parameterised cycle counter times a recovery window. Live outputs are flagged valid again only when that window expires. A per-pad keeper register remembers the last level each driven pad carried. When the feature is enabled, the two request pads are removed from the logic array: the array reads zero from them and their output drivers stay off.

Top module: `pdhold_top`

## Requirements
- R1: With the feature enabled, `pd_active` is high after every clock edge at which `pad_in[PDA_IDX]` or `pad_in[PDB_IDX]` was high, and low after an edge at which both were low.
- R2: When `cfg_pd_en` was low during reset, the request pins never cause a freeze: `pd_active` stays low, `core_clk_en` stays high, and those pins reach `arr_pad` like any other pad.
- R3: At an edge where the request is present, `arr_ded` and `arr_pad` keep their previous values whatever the inputs do.
- R4: At an edge where the request is present, `pad_out` and `pad_oe` keep their previous values, so a pad whose `pad_oe` bit is 0 stays undriven.
- R5: `core_clk_en` is low in exactly the cycles in which an enabled request is present on the pins, and high otherwise.
- R6: With the feature enabled, bits `PDA_IDX` and `PDB_IDX` of both `arr_pad` and `pad_oe` are always 0.
- R7: After each edge, bit i of `kept_level` equals the `pad_out[i]` value from before the edge if `pad_oe[i]` was 1 before the edge; if `pad_oe[i]` was 0, the bit is unchanged.
- R8: `out_valid` goes low at the first edge with a request present. It stays low until REC_CYCLES consecutive edges without a request have passed, and goes high at the last of them. A new request restarts the window.
- R9: `cfg_pd_en` is sampled only while `rst_n` is low; changing it after reset has no effect.
- R10: Synchronous reset (`rst_n` low at an edge) clears `arr_ded`, `arr_pad`, `pad_out`, `pad_oe`, `kept_level` and `pd_active`, and sets `out_valid` to 1.
- R11: With no request present, `arr_ded`, `arr_pad`, `pad_out` and `pad_oe` take the input values from before the edge after one clock edge, with the request pins masked as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pd_en | input | 1 | Power-down feature enable, captured during reset |
| ded_in | input | N_DED | Dedicated input pad levels |
| pad_in | input | N_IO | Bidirectional pad levels as seen at the pad |
| core_out | input | N_IO | Output data from the logic array |
| core_oe | input | N_IO | Output enables from the logic array |
| arr_ded | output | N_DED | Dedicated inputs as presented to the array |
| arr_pad | output | N_IO | Pad inputs as presented to the array |
| pad_out | output | N_IO | Output data to the pad drivers |
| pad_oe | output | N_IO | Output enables to the pad drivers |
| kept_level | output | N_IO | Keeper level of each pad |
| core_clk_en | output | 1 | Clock enable for the region's internal registers |
| pd_active | output | 1 | Region is frozen |
| out_valid | output | 1 | Live outputs valid (no freeze or recovery in progress) |

## Verification
The assertions assume that `cfg_pd_en` is held steady for the whole of every reset and that reset lasts at least two edges. The stability check on the captured enable and the masking check both rely on this. The bench holds the configuration bit constant during each reset. It changes the bit only after reset is released, which also exercises R9. All other inputs are changed only at the falling edge, so every value seen at a rising edge was set up half a cycle earlier. This respects the rule that inputs be valid before the freeze is requested.

// File: rtl/pdhold_pkg.sv
`timescale 1ns/1ps
package pdhold_pkg;

   typedef enum logic [1:0] {
      PH_RUN     = 2'd0,
      PH_HOLD    = 2'd1,
      PH_RECOVER = 2'd2
   } pd_phase_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/pdhold_ctrl.sv
`timescale 1ns/1ps
module pdhold_ctrl
   import pdhold_pkg::*;
#(
   parameter int unsigned REC_CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_pd_en,
   input  logic pin_a,
   input  logic pin_b,
   output logic en_q,
   output logic pd_req,
   output logic pd_active,
   output logic out_valid
);

   localparam int unsigned CNT_W = cnt_width(REC_CYCLES);
   localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYCLES);

   pd_phase_t        phase;
   logic [CNT_W-1:0] cnt;

   assign pd_req = en_q & (pin_a | pin_b);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= cfg_pd_en;
         phase <= PH_RUN;
         cnt   <= '0;
      end else if (pd_req) begin
         phase <= PH_HOLD;
         cnt   <= REC_LD;
      end else begin
         case (phase)
            PH_HOLD: begin
               if (REC_CYCLES == 1) begin
                  phase <= PH_RUN;
                  cnt   <= '0;
               end else begin
                  phase <= PH_RECOVER;
                  cnt   <= REC_LD - CNT_W'(1);
               end
            end
            PH_RECOVER: begin
               if (cnt == CNT_W'(1)) begin
                  phase <= PH_RUN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: begin
               phase <= PH_RUN;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign pd_active = (phase == PH_HOLD);
   assign out_valid = (phase == PH_RUN);

endmodule

// File: rtl/pdhold_freeze.sv
`timescale 1ns/1ps
module pdhold_freeze #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (!hold)
         q <= d;
   end

endmodule

// File: rtl/pdhold_keeper.sv
`timescale 1ns/1ps
module pdhold_keeper #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] drv_val,
   input  logic [W-1:0] drv_en,
   output logic [W-1:0] level
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            level[i] <= 1'b0;
         else if (drv_en[i])
            level[i] <= drv_val[i];
      end
   end

endmodule

// File: rtl/pdhold_top.sv
`timescale 1ns/1ps
module pdhold_top #(
   parameter int unsigned N_DED      = 4,
   parameter int unsigned N_IO       = 8,
   parameter int unsigned PDA_IDX    = 3,
   parameter int unsigned PDB_IDX    = 6,
   parameter int unsigned REC_CYCLES = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_pd_en,
   input  logic [N_DED-1:0] ded_in,
   input  logic [N_IO-1:0]  pad_in,
   input  logic [N_IO-1:0]  core_out,
   input  logic [N_IO-1:0]  core_oe,
   output logic [N_DED-1:0] arr_ded,
   output logic [N_IO-1:0]  arr_pad,
   output logic [N_IO-1:0]  pad_out,
   output logic [N_IO-1:0]  pad_oe,
   output logic [N_IO-1:0]  kept_level,
   output logic             core_clk_en,
   output logic             pd_active,
   output logic             out_valid
);

   if (N_DED < 1 || N_IO < 2) begin : g_bad_width
      $error("pdhold_top: need N_DED >= 1 and N_IO >= 2");
   end
   if (PDA_IDX >= N_IO || PDB_IDX >= N_IO) begin : g_bad_index
      $error("pdhold_top: power-down pin index outside pad range");
   end
   if (PDA_IDX == PDB_IDX) begin : g_same_index
      $error("pdhold_top: the two power-down pins must differ");
   end
   if (REC_CYCLES < 1) begin : g_bad_rec
      $error("pdhold_top: REC_CYCLES must be at least 1");
   end

   logic            pd_en_q;
   logic            pd_req;
   logic [N_IO-1:0] pin_mask;
   logic [N_IO-1:0] pad_masked;
   logic [N_IO-1:0] oe_masked;

   for (genvar i = 0; i < N_IO; i++) begin : g_mask
      if (i == PDA_IDX || i == PDB_IDX) begin : g_pd_pin
         assign pin_mask[i] = pd_en_q;
      end else begin : g_user_pin
         assign pin_mask[i] = 1'b0;
      end
   end

   assign pad_masked  = pad_in  & ~pin_mask;
   assign oe_masked   = core_oe & ~pin_mask;
   assign core_clk_en = ~pd_req;

   pdhold_ctrl #(.REC_CYCLES(REC_CYCLES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_pd_en (cfg_pd_en),
      .pin_a     (pad_in[PDA_IDX]),
      .pin_b     (pad_in[PDB_IDX]),
      .en_q      (pd_en_q),
      .pd_req    (pd_req),
      .pd_active (pd_active),
      .out_valid (out_valid)
   );

   pdhold_freeze #(.W(N_DED)) u_frz_ded (
      .clk(clk), .rst_n(rst_n), .hold(pd_req), .d(ded_in), .q(arr_ded)
   );

   pdhold_freeze #(.W(N_IO)) u_frz_pad (
      .clk(clk), .rst_n(rst_n), .hold(pd_req), .d(pad_masked), .q(arr_pad)
   );

   pdhold_freeze #(.W(N_IO)) u_frz_out (
      .clk(clk), .rst_n(rst_n), .hold(pd_req), .d(core_out), .q(pad_out)
   );

   pdhold_freeze #(.W(N_IO)) u_frz_oe (
      .clk(clk), .rst_n(rst_n), .hold(pd_req), .d(oe_masked), .q(pad_oe)
   );

   pdhold_keeper #(.W(N_IO)) u_keep (
      .clk     (clk),
      .rst_n   (rst_n),
      .drv_val (pad_out),
      .drv_en  (pad_oe),
      .level   (kept_level)
   );

endmodule

// File: rtl/pdhold_chk.sv
`timescale 1ns/1ps
module pdhold_chk #(
   parameter int unsigned N_DED   = 4,
   parameter int unsigned N_IO    = 8,
   parameter int unsigned PDA_IDX = 3,
   parameter int unsigned PDB_IDX = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_en_q,
   input logic [N_IO-1:0]  pad_in,
   input logic [N_DED-1:0] arr_ded,
   input logic [N_IO-1:0]  arr_pad,
   input logic [N_IO-1:0]  pad_out,
   input logic [N_IO-1:0]  pad_oe,
   input logic [N_IO-1:0]  kept_level,
   input logic             core_clk_en,
   input logic             pd_active,
   input logic             out_valid
);

   localparam logic [N_IO-1:0] PIN_MASK =
      (N_IO'(1) << PDA_IDX) | (N_IO'(1) << PDB_IDX);

   p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_en_q && (pad_in[PDA_IDX] || pad_in[PDB_IDX])) |=> pd_active);

   p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_en_q |-> (core_clk_en && !pd_active));

   p_hold_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |=> ($stable(arr_ded) && $stable(arr_pad)));

   p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |=> ($stable(pad_out) && $stable(pad_oe)));

   p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pd_en_q |-> (((pad_oe & PIN_MASK) == '0) && ((arr_pad & PIN_MASK) == '0)));

   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((kept_level ^ $past(pad_out)) & $past(pad_oe)) == '0));

   p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pd_active |-> !out_valid);

   p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_active) |-> !out_valid);

   p_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(pd_en_q));

endmodule

bind pdhold_top pdhold_chk #(
   .N_DED(N_DED), .N_IO(N_IO), .PDA_IDX(PDA_IDX), .PDB_IDX(PDB_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pd_en_q(pd_en_q), .pad_in(pad_in),
   .arr_ded(arr_ded), .arr_pad(arr_pad), .pad_out(pad_out), .pad_oe(pad_oe),
   .kept_level(kept_level), .core_clk_en(core_clk_en),
   .pd_active(pd_active), .out_valid(out_valid)
);

// File: tb/pdhold_top_tb.sv
`timescale 1ns/1ps
module pdhold_top_tb;

   localparam int N_DED = 4;
   localparam int N_IO  = 8;
   localparam int PA    = 3;
   localparam int PB    = 6;
   localparam int REC   = 250;
   localparam logic [N_IO-1:0] MSK = (N_IO'(1) << PA) | (N_IO'(1) << PB);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_pd_en = 1'b1;
   logic [N_DED-1:0] ded_in = '0;
   logic [N_IO-1:0]  pad_in = '0;
   logic [N_IO-1:0]  core_out = '0;
   logic [N_IO-1:0]  core_oe = '0;
   logic [N_DED-1:0] arr_ded;
   logic [N_IO-1:0]  arr_pad, pad_out, pad_oe, kept_level;
   logic             core_clk_en, pd_active, out_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   bit               en_m;
   logic [N_DED-1:0] ded_m;
   logic [N_IO-1:0]  pad_m, out_m, oe_m, keep_m;
   bit               pda_m;
   int               cnt_m;

   always #2 clk = ~clk;

   pdhold_top #(.N_DED(N_DED), .N_IO(N_IO), .PDA_IDX(PA), .PDB_IDX(PB),
                .REC_CYCLES(REC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .ded_in(ded_in),
      .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
      .arr_ded(arr_ded), .arr_pad(arr_pad), .pad_out(pad_out), .pad_oe(pad_oe),
      .kept_level(kept_level), .core_clk_en(core_clk_en),
      .pd_active(pd_active), .out_valid(out_valid)
   );

   task automatic chk(string req, string nm, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, nm, act, exp);
      end
   endtask

   task automatic model_edge();
      bit req;
      logic [N_IO-1:0] m;
      if (!rst_n) begin
         en_m = cfg_pd_en; ded_m = '0; pad_m = '0; out_m = '0; oe_m = '0;
         keep_m = '0; pda_m = 0; cnt_m = 0;
      end else begin
         req = en_m && (pad_in[PA] || pad_in[PB]);
         keep_m = (keep_m & ~oe_m) | (out_m & oe_m);
         m = en_m ? MSK : '0;
         if (!req) begin
            ded_m = ded_in; pad_m = pad_in & ~m; out_m = core_out; oe_m = core_oe & ~m;
         end
         pda_m = req;
         if (req) cnt_m = REC;
         else if (cnt_m > 0) cnt_m--;
      end
   endtask

   task automatic compare_all(bit in_reset);
      string ti, to;
      bit cen;
      ti = in_reset ? "R10" : (pda_m ? "R3" : "R11");
      to = in_reset ? "R10" : (pda_m ? "R4" : "R11");
      chk(ti, "arr_ded", int'(arr_ded), int'(ded_m));
      chk(ti, "arr_pad", int'(arr_pad), int'(pad_m));
      chk(to, "pad_out", int'(pad_out), int'(out_m));
      chk(to, "pad_oe",  int'(pad_oe),  int'(oe_m));
      chk(in_reset ? "R10" : "R7", "kept_level", int'(kept_level), int'(keep_m));
      chk(in_reset ? "R10" : "R1", "pd_active", int'(pd_active), int'(pda_m));
      chk(in_reset ? "R10" : "R8", "out_valid", int'(out_valid), int'(cnt_m == 0));
      if (!in_reset) begin
         cen = !(en_m && (pad_in[PA] || pad_in[PB]));
         chk("R5", "core_clk_en", int'(core_clk_en), int'(cen));
         if (en_m) chk("R6", "masked pins", int'((pad_oe | arr_pad) & MSK), 0);
      end
   endtask

   task automatic cycle();
      bit r;
      @(posedge clk);
      r = !rst_n;
      model_edge();
      @(negedge clk);
      compare_all(r);
   endtask

   task automatic rnd(bit a, bit b);
      ded_in   = N_DED'($urandom);
      pad_in   = N_IO'($urandom);
      pad_in[PA] = a;
      pad_in[PB] = b;
      core_out = N_IO'($urandom);
      core_oe  = N_IO'($urandom);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      // R10: reset with the feature enabled
      rst_n = 0; cfg_pd_en = 1;
      repeat (5) cycle();
      @(negedge clk);
      rst_n = 1;

      // R11, R6, R7: normal traffic
      repeat (40) begin rnd(0, 0); cycle(); end

      // R1, R3, R4, R5: freeze from the first pin, then recovery R8
      repeat (30) begin rnd(1, 0); cycle(); end
      repeat (REC + 10) begin rnd(0, 0); cycle(); end

      // second pin, both pins, then a request inside the recovery window (R8)
      repeat (20) begin rnd(0, 1); cycle(); end
      repeat (10) begin rnd(1, 1); cycle(); end
      repeat (100) begin rnd(0, 0); cycle(); end
      repeat (5) begin rnd(1, 0); cycle(); end
      repeat (REC + 10) begin rnd(0, 0); cycle(); end

      // R9: clearing the configuration bit after reset changes nothing
      cfg_pd_en = 0;
      repeat (5) begin rnd(0, 0); cycle(); end
      rnd(1, 0);
      cycle();
      chk("R9", "pd_active after late cfg change", int'(pd_active), 1);
      chk("R9", "core_clk_en after late cfg change", int'(core_clk_en), 0);
      repeat (REC + 5) begin rnd(0, 0); cycle(); end

      // R2: reset with the feature disabled
      rst_n = 0;
      repeat (4) cycle();
      @(negedge clk);
      rst_n = 1;
      cfg_pd_en = 1;
      rnd(1, 1);
      cycle();
      chk("R2", "pd_active", int'(pd_active), 0);
      chk("R2", "arr_pad pin A", int'(arr_pad[PA]), 1);
      chk("R2", "arr_pad pin B", int'(arr_pad[PB]), 1);
      chk("R2", "core_clk_en", int'(core_clk_en), 1);
      chk("R2", "out_valid", int'(out_valid), 1);
      repeat (30) begin rnd($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1); cycle(); end

      done = 1;
      summary();
      $finish;
   end

endmodule